// File: doc/BRIEF.md
# Stereo 24-bit Sample Serial Link

This block moves pairs of 24-bit audio samples across a three-wire serial link made of a word-select line, a bit clock and a data line. From a single-cycle enable that arrives once per bit period (64 times the sample rate), it makes the bit clock and word select. It shifts a left and a right sample out on the transmit data line, and it rebuilds the pair from a receive data line into parallel registers. When the pair is complete it gives a one-cycle valid strobe. A frame-sync output is high for a whole word-select period once every `SUBBANDS` periods. It marks the period that carries the lowest sub-band of each block of sub-band samples.

A word-select period is 64 bit slots long. Word select is low for slots 0 to 31, which carry the left sample, and high for slots 32 to 63, which carry the right sample. In each half, the first slot after the word-select change is empty. The 24 data bits follow, most significant bit first, and 7 more empty slots end the half. Word select and data change when the bit clock falls, and the receiver samples on the rising edge. The transmit FSM has seven named states:

- `ST_IDLE` is the state before the first enable.
- `ST_LEAD_L` covers slot 0. The transmit pair is latched on entry.
- `ST_DATA_L` covers slots 1 to 24.
- `ST_PAD_L` covers slots 25 to 31.
- `ST_LEAD_R` covers slot 32.
- `ST_DATA_R` covers slots 33 to 56.
- `ST_PAD_R` covers slots 57 to 63.

Each transition happens on a bit enable. `ST_IDLE`, `ST_LEAD_L` and `ST_LEAD_R` always move on to the next state. Each of the other states leaves when the next slot number reaches its boundary: 25, 32, 57 or 0. From `ST_PAD_R` the FSM returns to `ST_LEAD_L`. Bit enables must be at least two clock cycles apart.

Top module: `stereo_link`

## Requirements
- R1: After the first `bit_en`, `sclk` is low for exactly the cycle after each `bit_en` and high otherwise. Each half of the word-select period spans 32 `sclk` falls, and `ws` is low for the left half and high for the right half.
- R2: `ws` and `tx_sd` change only in a cycle in which `sclk` is low.
- R3: The left sample's bits 23 down to 0 appear in slots 1 to 24. The right sample's bits 23 down to 0 appear in slots 33 to 56. Slot 0 is the first slot with `ws` low, and slot 32 is the first slot with `ws` high.
- R4: Slots 0, 25 to 32 and 57 to 63 carry a low `tx_sd`.
- R5: `tx_left` and `tx_right` are latched on the enable that starts slot 0. Changes at other times have no effect on the frame in flight.
- R6: The receiver samples `rx_sd` at the rising edge of `sclk` and ignores its value in the empty slots.
- R7: `rx_valid` is high for exactly one cycle, while slot 56 is current, after the right-channel LSB has been captured. `rx_left` and `rx_right` then hold the two 24-bit words received in that word-select period.
- R8: `fsync` is constant over each word-select period. It is high in the first period after start and in every `SUBBANDS`-th period after that, and low in all the others.
- R9: While `rst_n` is low, `sclk` is high, and `ws`, `tx_sd`, `fsync`, `rx_valid`, `rx_left` and `rx_right` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable, once per bit period (64 x sample rate) |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| rx_sd | input | 1 | Serial data received |
| sclk | output | 1 | Generated bit clock |
| ws | output | 1 | Word select, low = left, high = right |
| tx_sd | output | 1 | Serial data transmitted |
| fsync | output | 1 | High during the word-select period of sub-band 0 |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe when a received pair is complete |

## Verification
A slot counter that is out by one shows within a single bit period. The wrong bit appears on `tx_sd`, or a data bit lands in an empty slot, or the half-period length moves off 32. A frame counter that is wrong moves `fsync` to the wrong word-select period, which shows within `SUBBANDS` frames. A transmit FSM or shift register that is out of step returns a corrupted pair at the next `rx_valid` in loopback, which is at most one frame later. The bench injects ones into the empty receive slots to catch a capture window that is too wide. It changes the transmit inputs mid-frame to catch a latch that happens at the wrong time.

// File: rtl/stl_pkg.sv
package stl_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int HALF_SLOTS = 32;
    localparam int SLOT_W     = $clog2(2 * HALF_SLOTS);
    localparam int PAIR_W     = 2 * SAMPLE_W;

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t SLOT_L_FIRST = slot_t'(1);
    localparam slot_t SLOT_L_LAST  = slot_t'(SAMPLE_W);
    localparam slot_t SLOT_L_PAD   = slot_t'(SAMPLE_W + 1);
    localparam slot_t SLOT_R_LEAD  = slot_t'(HALF_SLOTS);
    localparam slot_t SLOT_R_FIRST = slot_t'(HALF_SLOTS + 1);
    localparam slot_t SLOT_R_LAST  = slot_t'(HALF_SLOTS + SAMPLE_W);
    localparam slot_t SLOT_R_PAD   = slot_t'(HALF_SLOTS + SAMPLE_W + 1);
    localparam slot_t SLOT_TOP     = slot_t'(2 * HALF_SLOTS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_L,
        ST_DATA_L,
        ST_PAD_L,
        ST_LEAD_R,
        ST_DATA_R,
        ST_PAD_R
    } tx_state_e;

endpackage

// File: rtl/stl_clkgen.sv
module stl_clkgen
    import stl_pkg::*;
#(
    parameter int SUBBANDS = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    output logic  sclk,
    output logic  ws,
    output logic  fsync,
    output logic  rise,
    output slot_t slot,
    output slot_t next_slot
);

    localparam int FCNT_W = (SUBBANDS > 1) ? $clog2(SUBBANDS) : 1;
    localparam logic [FCNT_W-1:0] LAST_FRAME = FCNT_W'(SUBBANDS - 1);

    logic              running_q;
    logic              sclk_q;
    logic              rise_q;
    slot_t             slot_q;
    logic [FCNT_W-1:0] frame_q;

    // the slot entered on the next enable; the first enable starts slot 0
    assign next_slot = running_q ? slot_q + slot_t'(1) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            sclk_q    <= 1'b1;
            rise_q    <= 1'b0;
            slot_q    <= '0;
            frame_q   <= '0;
        end else begin
            rise_q <= bit_en;
            if (bit_en) begin
                running_q <= 1'b1;
                slot_q    <= next_slot;
                sclk_q    <= 1'b0;
                if (running_q && slot_q == SLOT_TOP) begin
                    frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
                end
            end else begin
                sclk_q <= 1'b1;
            end
        end
    end

    assign sclk  = sclk_q;
    assign ws    = slot_q[SLOT_W-1];
    assign fsync = running_q && (frame_q == '0);
    assign rise  = rise_q;
    assign slot  = slot_q;

endmodule

// File: rtl/stl_tx.sv
module stl_tx
    import stl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  slot_t               next_slot,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                sd
);

    tx_state_e           state_q;
    tx_state_e           state_d;
    logic [PAIR_W-1:0]   shreg_q;
    logic                bit_q;

    // next-state logic, taken only on a bit enable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_LEAD_L;
            ST_LEAD_L: state_d = ST_DATA_L;
            ST_DATA_L: state_d = (next_slot == SLOT_L_PAD)   ? ST_PAD_L  : ST_DATA_L;
            ST_PAD_L:  state_d = (next_slot == SLOT_R_LEAD)  ? ST_LEAD_R : ST_PAD_L;
            ST_LEAD_R: state_d = ST_DATA_R;
            ST_DATA_R: state_d = (next_slot == SLOT_R_PAD)   ? ST_PAD_R  : ST_DATA_R;
            ST_PAD_R:  state_d = (next_slot == '0)           ? ST_LEAD_L : ST_PAD_R;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (bit_en) begin
            state_q <= state_d;
        end
    end

    // pair latch and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= 1'b0;
        end else if (bit_en) begin
            if (state_d == ST_LEAD_L) begin
                shreg_q <= {smp_left, smp_right};
                bit_q   <= 1'b0;
            end else if (state_d == ST_DATA_L || state_d == ST_DATA_R) begin
                bit_q   <= shreg_q[PAIR_W-1];
                shreg_q <= {shreg_q[PAIR_W-2:0], 1'b0};
            end else begin
                bit_q   <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DATA_L, ST_DATA_R: sd = bit_q;
            default:              sd = 1'b0;
        endcase
    end

endmodule

// File: rtl/stl_rx.sv
module stl_rx
    import stl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  slot_t               slot,
    input  logic                sd_in,
    output logic [SAMPLE_W-1:0] word_left,
    output logic [SAMPLE_W-1:0] word_right,
    output logic                valid
);

    logic [SAMPLE_W-1:0] acc_l_q;
    logic [SAMPLE_W-1:0] acc_r_q;
    logic [SAMPLE_W-1:0] out_l_q;
    logic [SAMPLE_W-1:0] out_r_q;
    logic                valid_q;
    logic                in_left;
    logic                in_right;

    assign in_left  = (slot >= SLOT_L_FIRST) && (slot <= SLOT_L_LAST);
    assign in_right = (slot >= SLOT_R_FIRST) && (slot <= SLOT_R_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_l_q <= '0;
            acc_r_q <= '0;
            out_l_q <= '0;
            out_r_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (rise) begin
                if (in_left) begin
                    acc_l_q <= {acc_l_q[SAMPLE_W-2:0], sd_in};
                end
                if (in_right) begin
                    acc_r_q <= {acc_r_q[SAMPLE_W-2:0], sd_in};
                end
                if (slot == SLOT_R_LAST) begin
                    out_l_q <= acc_l_q;
                    out_r_q <= {acc_r_q[SAMPLE_W-2:0], sd_in};
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign word_left  = out_l_q;
    assign word_right = out_r_q;
    assign valid      = valid_q;

endmodule

// File: rtl/stereo_link.sv
module stereo_link
    import stl_pkg::*;
#(
    parameter int SUBBANDS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                rx_sd,
    output logic                sclk,
    output logic                ws,
    output logic                tx_sd,
    output logic                fsync,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    slot_t w_slot;
    slot_t w_next_slot;
    logic  w_rise;

    stl_clkgen #(
        .SUBBANDS (SUBBANDS)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .sclk      (sclk),
        .ws        (ws),
        .fsync     (fsync),
        .rise      (w_rise),
        .slot      (w_slot),
        .next_slot (w_next_slot)
    );

    stl_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .next_slot (w_next_slot),
        .smp_left  (tx_left),
        .smp_right (tx_right),
        .sd        (tx_sd)
    );

    stl_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (w_rise),
        .slot       (w_slot),
        .sd_in      (rx_sd),
        .word_left  (rx_left),
        .word_right (rx_right),
        .valid      (rx_valid)
    );

endmodule

// File: rtl/stereo_link_chk.sv
module stereo_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       sclk,
    input logic       ws,
    input logic       tx_sd,
    input logic       fsync,
    input logic       rx_valid,
    input logic [5:0] slot
);

    logic empty_slot;
    assign empty_slot = (slot == 6'd0) || (slot >= 6'd25 && slot <= 6'd32) || (slot >= 6'd57);

    AST_SCLK_LOW_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && $past(rst_n)) |-> !sclk); // R1

    AST_WS_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ws != $past(ws)) |-> !sclk); // R2

    AST_SD_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sd != $past(tx_sd)) |-> !sclk); // R2

    AST_EMPTY_SLOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty_slot |-> !tx_sd); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_VALID_AT_RIGHT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (slot == 6'd56)); // R7

    AST_FSYNC_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync != $past(fsync)) |-> (slot == 6'd0)); // R8

endmodule

bind stereo_link stereo_link_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sclk     (sclk),
    .ws       (ws),
    .tx_sd    (tx_sd),
    .fsync    (fsync),
    .rx_valid (rx_valid),
    .slot     (w_slot)
);

// File: tb/stereo_link_tb.sv
module stereo_link_tb;

    localparam int NSB = 4;
    localparam int NF  = 9;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
    } pair_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_en;
    logic [23:0] tx_left;
    logic [23:0] tx_right;
    logic        rx_sd;
    logic        sclk;
    logic        ws;
    logic        tx_sd;
    logic        fsync;
    logic [23:0] rx_left;
    logic [23:0] rx_right;
    logic        rx_valid;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    noise_en = 0;
    bit    pad_now  = 0;
    pair_t q[$];

    always #10 clk = ~clk;

    assign rx_sd = tx_sd | (noise_en & pad_now);

    stereo_link #(.SUBBANDS(NSB)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .rx_sd    (rx_sd),
        .sclk     (sclk),
        .ws       (ws),
        .tx_sd    (tx_sd),
        .fsync    (fsync),
        .rx_left  (rx_left),
        .rx_right (rx_right),
        .rx_valid (rx_valid)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic pair_t pat(input int k);
        pair_t p;
        case (k)
            0: begin p.l = 24'h800000; p.r = 24'h000001; end
            1: begin p.l = 24'hFFFFFF; p.r = 24'h000000; end
            2: begin p.l = 24'hAAAAAA; p.r = 24'h555555; end
            default: begin
                p.l = 24'(k * 32'h9E3779);
                p.r = 24'(k * 32'h9E3779) ^ 24'h5A5A5A;
            end
        endcase
        return p;
    endfunction

    task automatic apply(input pair_t p, input bit push);
        tx_left  = p.l;
        tx_right = p.r;
        if (push) q.push_back(p);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // bit enable: one pulse every 4 clocks
    initial begin
        bit_en = 1'b0;
        wait (rst_n === 1'b1);
        forever begin
            repeat (3) @(negedge clk);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
        end
    end

    // driver
    initial begin
        pair_t junk;
        junk.l = 24'hDEAD00;
        junk.r = 24'h00BEEF;
        rst_n = 1'b0;
        apply(pat(0), 1'b0);
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(sclk == 1'b1, "R9", sclk, 1);
        chk(ws == 1'b0, "R9", ws, 0);
        chk(tx_sd == 1'b0, "R9", tx_sd, 0);
        chk(fsync == 1'b0, "R9", fsync, 0);
        chk(rx_valid == 1'b0, "R9", rx_valid, 0);
        chk(rx_left == 24'd0 && rx_right == 24'd0, "R9", {8'd0, rx_left}, 0);
        q.push_back(pat(0));
        rst_n = 1'b1;
        for (int k = 1; k <= NF; k++) begin
            @(posedge ws);
            @(negedge clk);
            apply(pat(k), 1'b1);
            if (k >= 4) noise_en = 1;
            @(negedge ws);
            repeat (20) @(negedge clk);
            apply(junk, 1'b0);   // R5: mid-frame change, not latched here
        end
        @(posedge ws);
        @(negedge clk);
        apply(pat(NF + 1), 1'b1);
        while (q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        finish_run();
    end

    // monitor and scoreboard
    initial begin
        bit   prev_sclk = 1'b1;
        bit   prev_ws   = 1'b0;
        bit   prev_sd   = 1'b0;
        bit   prev_valid = 1'b0;
        bit   started   = 1'b0;
        bit   last_slot_ws = 1'b0;
        bit   fsync_frame = 1'b0;
        int   slot_b = 0;
        int   half_cnt = 0;
        int   frame_idx = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ws != prev_ws) chk(sclk == 1'b0, "R2", sclk, 0);
                if (tx_sd != prev_sd) chk(sclk == 1'b0, "R2", sclk, 0);
                if (prev_sclk && !sclk) begin
                    if (!started) begin
                        started = 1;
                        slot_b = 0;
                        half_cnt = 1;
                        frame_idx = 0;
                        fsync_frame = fsync;
                        chk(fsync == 1'b1, "R8", fsync, 1);
                    end else if (ws != last_slot_ws) begin
                        chk(half_cnt == 32, "R1", half_cnt, 32);
                        half_cnt = 1;
                        slot_b = ws ? 32 : 0;
                        if (!ws) begin
                            frame_idx++;
                            fsync_frame = fsync;
                            chk(fsync == ((frame_idx % NSB) == 0), "R8", fsync, ((frame_idx % NSB) == 0));
                        end
                    end else begin
                        slot_b++;
                        half_cnt++;
                        chk(fsync == fsync_frame, "R8", fsync, fsync_frame);
                    end
                    last_slot_ws = ws;
                    if (slot_b >= 1 && slot_b <= 24) begin
                        pad_now = 0;
                        if (q.size() != 0) chk(tx_sd == q[0].l[24 - slot_b], "R3", tx_sd, q[0].l[24 - slot_b]);
                    end else if (slot_b >= 33 && slot_b <= 56) begin
                        pad_now = 0;
                        if (q.size() != 0) chk(tx_sd == q[0].r[56 - slot_b], "R3", tx_sd, q[0].r[56 - slot_b]);
                    end else begin
                        pad_now = 1;
                        chk(tx_sd == 1'b0, "R4", tx_sd, 0);
                    end
                end
                if (rx_valid) begin
                    chk(!prev_valid, "R7", prev_valid, 0);
                    chk(slot_b == 56, "R7", slot_b, 56);
                    if (q.size() == 0) begin
                        chk(1'b0, "R7", 1, 0);
                    end else begin
                        pair_t p;
                        p = q.pop_front();
                        chk(rx_left == p.l, noise_en ? "R6" : "R5", rx_left, p.l);
                        chk(rx_right == p.r, noise_en ? "R6" : "R5", rx_right, p.r);
                    end
                end
                // R1: sclk low only in the cycle after an enable
                if (started) chk(sclk == !prev_bit_en_s, "R1", sclk, !prev_bit_en_s);
                prev_sclk  = sclk;
                prev_ws    = ws;
                prev_sd    = tx_sd;
                prev_valid = rx_valid;
            end
        end
    end

    // enable as seen at the last rising edge
    logic prev_bit_en_s = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            prev_bit_en_s = en_at_edge;
        end
    end

    logic en_at_edge = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            en_at_edge = bit_en;
        end
    end

endmodule